// File: doc/BRIEF.md
# External Register Strobe Timer

This block times the active-low select strobe used when the chip reaches a register that sits outside it, on a slow local bus. A request pulse from the bus-side controller starts one access. The block samples the 3-bit length setting held in the device configuration word. It drives the strobe low for the number of bus clocks that setting encodes, then reports completion with a one-clock pulse.

The length setting is not a plain binary count. The all-zero value gives the longest strobe, and the values just above zero are reserved. A reserved setting still produces a usable strobe of the longest length, but it also raises a sticky error flag that stays set until the next accepted request. The setting is sampled only when a request is accepted, so software may rewrite it while an access is under way. Requests that arrive while the strobe is low are dropped.

Top module: `ext_cs_timer`

## Requirements
- R1: After reset the strobe `ext_cs_n_o` is high, `done_o` is low and `code_err_o` is low. They stay that way while no request arrives.
- R2: Setting 3'b000 gives a strobe that is low for exactly 8 clocks.
- R3: Settings 3'b100, 3'b101, 3'b110 and 3'b111 give strobes that are low for exactly 4, 5, 6 and 7 clocks. For these settings the length equals the setting read as an unsigned number.
- R4: Setting 3'b011 gives a strobe that is low for exactly 3 clocks.
- R5: Settings 3'b001 and 3'b010 are reserved. They give an 8-clock strobe and set `code_err_o` from the clock after the request is accepted.
- R6: `code_err_o` holds its value between accepted requests. A request accepted with a non-reserved setting clears it from the following clock.
- R7: The setting is captured in the clock where the request is accepted. Later changes to `width_code_i` do not change the length of the access under way.
- R8: A request seen while the strobe is low is ignored. It neither lengthens the strobe nor causes any extra `done_o` pulse.
- R9: A request seen while the strobe is high is accepted. The strobe is low in the very next clock.
- R10: `done_o` is high for exactly one clock. That clock is the first clock in which the strobe is high again after an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin one external access |
| width_code_i | input | CODE_W (3) | Strobe length setting from the configuration word |
| ext_cs_n_o | output | 1 | Active-low external select strobe |
| done_o | output | 1 | One-clock completion pulse |
| code_err_o | output | 1 | Sticky flag: last accepted setting was reserved |

## Verification
The bench builds the block with its default 3-bit setting, so every one of the eight settings can be swept in turn. This covers both reserved values and the wrap from the all-zero value to the longest length. It instantiates the block twice, once with the down-counting length counter and once with the up-counting one, and requires the two to behave the same on every access. Each setting is run three ways: undisturbed, with the setting rewritten during the strobe, and with a request held high throughout the strobe, which brings capture and request dropping within reach.

// File: rtl/ecs_pkg.sv
package ecs_pkg;

   // control state of one external access
   typedef enum logic {
      ECS_IDLE  = 1'b0,
      ECS_DRIVE = 1'b1
   } ecs_state_e;

endpackage

// File: rtl/ecs_width_decode.sv
module ecs_width_decode #(
   parameter int CODE_W   = 3,
   parameter int MIN_CODE = 3,
   parameter int LEN_W    = 4
) (
   input  logic [CODE_W-1:0] code_i,
   output logic [LEN_W-1:0]  len_o,
   output logic              reserved_o
);

   localparam int                LONG_LEN = 1 << CODE_W;
   localparam logic [LEN_W-1:0]  LONG_V   = LEN_W'(LONG_LEN);
   localparam logic [CODE_W-1:0] MIN_V    = CODE_W'(MIN_CODE);
   localparam logic [CODE_W-1:0] ZERO_V   = '0;

   logic is_zero;

   always_comb begin
      is_zero    = (code_i == ZERO_V);
      reserved_o = !is_zero && (code_i < MIN_V);
      if (is_zero || reserved_o) begin
         len_o = LONG_V;
      end else begin
         len_o = LEN_W'(code_i);
      end
   end

endmodule

// File: rtl/ecs_len_counter.sv
module ecs_len_counter #(
   parameter int LEN_W      = 4,
   parameter bit COUNT_DOWN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [LEN_W-1:0] len_i,
   input  logic             step_i,
   output logic             last_o
);

   localparam logic [LEN_W-1:0] ONE_V = LEN_W'(1);

   generate
      if (COUNT_DOWN) begin : g_down
         logic [LEN_W-1:0] remain_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               remain_q <= '0;
            end else if (load_i) begin
               remain_q <= len_i - ONE_V;
            end else if (step_i) begin
               remain_q <= remain_q - ONE_V;
            end
         end

         assign last_o = (remain_q == '0);
      end else begin : g_up
         logic [LEN_W-1:0] elapsed_q;
         logic [LEN_W-1:0] target_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               elapsed_q <= '0;
               target_q  <= '0;
            end else if (load_i) begin
               elapsed_q <= '0;
               target_q  <= len_i - ONE_V;
            end else if (step_i) begin
               elapsed_q <= elapsed_q + ONE_V;
            end
         end

         assign last_o = (elapsed_q == target_q);
      end
   endgenerate

endmodule

// File: rtl/ecs_cs_ctrl.sv
module ecs_cs_ctrl
   import ecs_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic reserved_i,
   input  logic last_i,
   output logic load_o,
   output logic step_o,
   output logic cs_n_o,
   output logic done_o,
   output logic err_o
);

   ecs_state_e state_q;
   logic       done_q;
   logic       err_q;

   always_comb begin
      load_o = (state_q == ECS_IDLE) && start_i;
      step_o = (state_q == ECS_DRIVE) && !last_i;
      cs_n_o = (state_q != ECS_DRIVE);
      done_o = done_q;
      err_o  = err_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ECS_IDLE;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ECS_IDLE: begin
               if (start_i) begin
                  state_q <= ECS_DRIVE;
                  err_q   <= reserved_i;
               end
            end
            ECS_DRIVE: begin
               if (last_i) begin
                  state_q <= ECS_IDLE;
                  done_q  <= 1'b1;
               end
            end
            default: state_q <= ECS_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/ext_cs_timer.sv
module ext_cs_timer #(
   parameter int CODE_W     = 3,
   parameter int MIN_CODE   = 3,
   parameter bit COUNT_DOWN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [CODE_W-1:0] width_code_i,
   output logic              ext_cs_n_o,
   output logic              done_o,
   output logic              code_err_o
);

   localparam int LONG_LEN = 1 << CODE_W;
   localparam int LEN_W    = $clog2(LONG_LEN + 1);

   generate
      if (CODE_W < 2 || CODE_W > 6) begin : g_bad_code_w
         $error("ext_cs_timer: CODE_W must lie in 2..6");
      end
      if (MIN_CODE < 1 || MIN_CODE >= LONG_LEN) begin : g_bad_min_code
         $error("ext_cs_timer: MIN_CODE must lie in 1..2**CODE_W-1");
      end
   endgenerate

   logic [LEN_W-1:0] dec_len;
   logic             dec_reserved;
   logic             ctr_load;
   logic             ctr_step;
   logic             ctr_last;

   ecs_width_decode #(
      .CODE_W   (CODE_W),
      .MIN_CODE (MIN_CODE),
      .LEN_W    (LEN_W)
   ) decode_i (
      .code_i     (width_code_i),
      .len_o      (dec_len),
      .reserved_o (dec_reserved)
   );

   ecs_len_counter #(
      .LEN_W      (LEN_W),
      .COUNT_DOWN (COUNT_DOWN)
   ) counter_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (ctr_load),
      .len_i  (dec_len),
      .step_i (ctr_step),
      .last_o (ctr_last)
   );

   ecs_cs_ctrl ctrl_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .reserved_i (dec_reserved),
      .last_i     (ctr_last),
      .load_o     (ctr_load),
      .step_o     (ctr_step),
      .cs_n_o     (ext_cs_n_o),
      .done_o     (done_o),
      .err_o      (code_err_o)
   );

endmodule

// File: rtl/ext_cs_timer_chk.sv
module ext_cs_timer_chk #(
   parameter int CODE_W   = 3,
   parameter int MIN_CODE = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic [CODE_W-1:0] width_code_i,
   input logic              ext_cs_n_o,
   input logic              done_o,
   input logic              code_err_o
);

   localparam int LONG_LEN = 1 << CODE_W;

   logic accept;
   logic rsv;
   int   want_len;
   int   low_run;
   int   low_want;

   always_comb begin
      accept   = start_i && ext_cs_n_o;
      rsv      = (int'(width_code_i) != 0) && (int'(width_code_i) < MIN_CODE);
      want_len = (int'(width_code_i) == 0 || rsv) ? LONG_LEN : int'(width_code_i);
   end

   // window counter: clocks spent low since the last acceptance
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_run  <= 0;
         low_want <= LONG_LEN;
      end else if (accept) begin
         low_run  <= 0;
         low_want <= want_len;
      end else if (!ext_cs_n_o) begin
         low_run  <= low_run + 1;
      end
   end

   // R2 R3 R4 R5 R7: strobe length matches the setting captured at acceptance
   p_len_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ext_cs_n_o) |-> (low_run == low_want));

   p_cs_follows_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !ext_cs_n_o);

   p_done_after_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (ext_cs_n_o && !$past(ext_cs_n_o)));

   p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_err_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && rsv) |=> code_err_o);

   p_err_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !rsv) |=> !code_err_o);

   p_err_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !accept |=> $stable(code_err_o));

   p_no_overrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !ext_cs_n_o |-> (low_run < low_want));

endmodule

bind ext_cs_timer ext_cs_timer_chk #(
   .CODE_W   (CODE_W),
   .MIN_CODE (MIN_CODE)
) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .start_i      (start_i),
   .width_code_i (width_code_i),
   .ext_cs_n_o   (ext_cs_n_o),
   .done_o       (done_o),
   .code_err_o   (code_err_o)
);

// File: tb/ext_cs_timer_tb_top.sv
`timescale 1ns/1ps
module ext_cs_timer_tb_top;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       start;
   logic [2:0] code;
   logic       cs_n, done, err;
   logic       cs_n_u, done_u, err_u;
   int         checks = 0;
   int         errors = 0;

   always #2 clk = ~clk;   // 250 MHz

   ext_cs_timer #(.CODE_W(3), .MIN_CODE(3), .COUNT_DOWN(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start), .width_code_i(code),
      .ext_cs_n_o(cs_n), .done_o(done), .code_err_o(err));

   ext_cs_timer #(.CODE_W(3), .MIN_CODE(3), .COUNT_DOWN(1'b0)) dut_up_i (
      .clk(clk), .rst_n(rst_n), .start_i(start), .width_code_i(code),
      .ext_cs_n_o(cs_n_u), .done_o(done_u), .code_err_o(err_u));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_len(input int c);
      return (c >= 3) ? c : 8;
   endfunction

   function automatic string len_req(input int c, input int mode);
      if (mode == 1) return "R7";
      if (mode == 2) return "R8";
      if (c == 0) return "R2";
      if (c == 3) return "R4";
      if (c >= 4) return "R3";
      return "R5";
   endfunction

   // mode 0: plain, 1: setting rewritten during strobe, 2: request held during strobe
   task automatic access(input int c, input int mode);
      int  n = 0;
      int  extra_done = 0;
      bit  same = 1'b1;
      bit  rsv = (c == 1 || c == 2);
      @(negedge clk);
      start = 1'b1;
      code  = 3'(c);
      @(negedge clk);
      start = 1'b0;
      chk(cs_n == 1'b0, "R9", int'(cs_n), 0);
      if (mode == 1) code = 3'(~c);
      while (cs_n == 1'b0 && n < 20) begin
         n++;
         if (done) extra_done++;
         if (cs_n_u != cs_n || done_u != done || err_u != err) same = 1'b0;
         if (mode == 2) start = 1'b1;
         @(negedge clk);
      end
      start = 1'b0;
      chk(n == exp_len(c), len_req(c, mode), n, exp_len(c));
      chk(extra_done == 0, "R8", extra_done, 0);
      chk(done == 1'b1, "R10", int'(done), 1);
      chk(err == rsv, rsv ? "R5" : "R6", int'(err), int'(rsv));
      chk(same && cs_n_u == cs_n && done_u == done, "R2 counter variants agree",
          int'(same), 1);
      @(negedge clk);
      chk(done == 1'b0, "R10", int'(done), 0);
      chk(cs_n == 1'b1, "R8", int'(cs_n), 1);
   endtask

   initial begin
      rst_n = 1'b0;
      start = 1'b0;
      code  = 3'b000;
      repeat (3) @(negedge clk);
      chk(cs_n == 1'b1 && done == 1'b0 && err == 1'b0, "R1", {cs_n, done, err}, 3'b100);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(cs_n == 1'b1 && done == 1'b0 && err == 1'b0, "R1", {cs_n, done, err}, 3'b100);

      for (int mode = 0; mode < 3; mode++) begin
         for (int c = 0; c < 8; c++) begin
            access(c, mode);
         end
      end

      // sticky error across idle time, then cleared by a valid setting
      access(2, 0);
      code = 3'b111;
      repeat (6) @(negedge clk);
      chk(err == 1'b1, "R6", int'(err), 1);
      access(5, 0);
      repeat (3) @(negedge clk);
      chk(err == 1'b0, "R6", int'(err), 0);

      // back-to-back: a new request right after the done pulse is accepted
      access(4, 0);
      access(3, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog R10 actual=hung expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule